// File: doc/BRIEF.md
# Pipeline Bypass and Hazard Control Unit

This block resolves data and control hazards for an in-order pipeline with fetch, decode, execute, memory and write-back stages. It compares the two source register numbers of the instruction in execute against the destinations of the older instructions in the memory and write-back stages. From that comparison it drives the select lines of the two ALU operand bypass multiplexers, so a result can be used before it reaches the register file.

A load cannot supply its data in time for the instruction directly behind it. For that case the unit holds the PC and the fetch/decode register for one cycle and turns the execute-stage entry into a no-op. Branches are predicted not taken and resolve in decode. When one turns out taken, the unit squashes the single instruction already fetched on the wrong path. The whole unit is combinational. The clock and reset serve only its cycle checks.

Top module: `hazard_unit`

## Requirements
- R1: An operand select is 2'b10 (take the memory-stage result) when the memory stage writes a register (`mem_we`=1), its destination equals that execute source, and the source is not register 0.
- R2: An operand select is 2'b01 (take the write-back result) when the write-back stage writes a register whose number equals that execute source, the source is not register 0, and R1 does not apply.
- R3: When both the memory and write-back stages match the same source, the memory-stage result wins (select 2'b10).
- R4: When neither stage matches, the select is 2'b00 (register file value). This covers a producer three instructions back, which the register file already delivers by writing in the first half of a cycle.
- R5: Register 0 never produces a bypass select other than 2'b00 and never causes a stall.
- R6: A load-use hazard exists when the execute stage holds a load (`ex_load`=1, `ex_we`=1) whose nonzero destination equals either decode source. In that case `pc_hold`, `ifid_hold` and `idex_bubble` are all 1 in the same cycle.
- R7: With no load-use hazard, all three stall outputs are 0. A load followed by a dependent instruction therefore costs exactly one bubble cycle.
- R8: `ifid_flush` is 1 exactly when `br_taken` is 1 and no stall is active in that cycle.
- R9: Operands A and B are selected independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock used by the cycle checks |
| rst_n | input | 1 | Active-low reset for the cycle checks |
| id_src_a | input | 5 | First source register of the instruction in decode |
| id_src_b | input | 5 | Second source register of the instruction in decode |
| ex_src_a | input | 5 | First source register of the instruction in execute |
| ex_src_b | input | 5 | Second source register of the instruction in execute |
| ex_dst | input | 5 | Destination of the instruction in execute |
| ex_we | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction reads data memory |
| mem_dst | input | 5 | Destination of the instruction in memory stage |
| mem_we | input | 1 | Memory-stage instruction writes a register |
| wb_dst | input | 5 | Destination of the instruction in write-back |
| wb_we | input | 1 | Write-back instruction writes a register |
| br_taken | input | 1 | Branch resolved in decode is taken |
| fwd_sel_a | output | 2 | Bypass select for operand A |
| fwd_sel_b | output | 2 | Bypass select for operand B |
| pc_hold | output | 1 | Keep PC unchanged |
| ifid_hold | output | 1 | Keep fetch/decode register unchanged |
| idex_bubble | output | 1 | Load a no-op into decode/execute register |
| ifid_flush | output | 1 | Squash the wrong-path fetched instruction |

## Verification
On every cycle, the assertions check four things: register 0 never bypasses or stalls, a write-back select only appears when the memory stage does not match, the three stall outputs move together, and a taken branch flushes unless a stall is active. Several behaviours need the bench's pipeline scenarios instead. These are the add/sub/and/or chain stepping from memory bypass to write-back bypass to no bypass, the single bubble after a load, and the priority choice under random register collisions.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
    typedef enum logic [1:0] {
        FWD_RF  = 2'b00,
        FWD_WB  = 2'b01,
        FWD_MEM = 2'b10
    } fwd_sel_t;

    typedef struct packed {
        logic stall;
        logic flush;
    } ctl_t;
endpackage

// File: rtl/bypass_select.sv
module bypass_select
    import hazard_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] mem_dst,
    input  logic          mem_we,
    input  logic [AW-1:0] wb_dst,
    input  logic          wb_we,
    output fwd_sel_t      sel
);
    localparam logic [AW-1:0] ZERO_REG = '0;

    logic mem_hit_d;
    logic wb_hit_d;
    fwd_sel_t sel_d;

    always_comb begin
        mem_hit_d = mem_we && (mem_dst == src) && (src != ZERO_REG);
        wb_hit_d  = wb_we  && (wb_dst  == src) && (src != ZERO_REG);
        if (mem_hit_d)     sel_d = FWD_MEM;
        else if (wb_hit_d) sel_d = FWD_WB;
        else               sel_d = FWD_RF;
    end

    assign sel = sel_d;

    assert_zero_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (src == ZERO_REG) |-> (sel == FWD_RF));

    assert_wb_yields_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == FWD_WB) |-> !(mem_we && mem_dst == src));

    assert_wb_needs_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == FWD_WB) |-> (wb_we && wb_dst == src));
endmodule

// File: rtl/load_use_detect.sv
module load_use_detect #(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ex_dst,
    input  logic          ex_we,
    input  logic          ex_load,
    input  logic [AW-1:0] id_src_a,
    input  logic [AW-1:0] id_src_b,
    output logic          stall
);
    localparam logic [AW-1:0] ZERO_REG = '0;

    logic stall_d;

    always_comb begin
        stall_d = ex_load && ex_we && (ex_dst != ZERO_REG) &&
                  ((ex_dst == id_src_a) || (ex_dst == id_src_b));
    end

    assign stall = stall_d;

    assert_zero_dst_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_dst == ZERO_REG) |-> !stall);

    assert_only_loads_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_load |-> !stall);
endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
    import hazard_pkg::*;
#(
    parameter int AW      = 5,
    parameter int NUM_SRC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] id_src_a,
    input  logic [AW-1:0] id_src_b,
    input  logic [AW-1:0] ex_src_a,
    input  logic [AW-1:0] ex_src_b,
    input  logic [AW-1:0] ex_dst,
    input  logic          ex_we,
    input  logic          ex_load,
    input  logic [AW-1:0] mem_dst,
    input  logic          mem_we,
    input  logic [AW-1:0] wb_dst,
    input  logic          wb_we,
    input  logic          br_taken,
    output logic [1:0]    fwd_sel_a,
    output logic [1:0]    fwd_sel_b,
    output logic          pc_hold,
    output logic          ifid_hold,
    output logic          idex_bubble,
    output logic          ifid_flush
);
    logic [AW-1:0] ex_src [NUM_SRC];
    fwd_sel_t      sel    [NUM_SRC];
    logic          stall;
    ctl_t          ctl_d;

    assign ex_src[0] = ex_src_a;
    assign ex_src[1] = ex_src_b;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_operand
        bypass_select #(.AW(AW)) u_sel (
            .clk     (clk),
            .rst_n   (rst_n),
            .src     (ex_src[i]),
            .mem_dst (mem_dst),
            .mem_we  (mem_we),
            .wb_dst  (wb_dst),
            .wb_we   (wb_we),
            .sel     (sel[i])
        );
    end

    load_use_detect #(.AW(AW)) u_lu (
        .clk      (clk),
        .rst_n    (rst_n),
        .ex_dst   (ex_dst),
        .ex_we    (ex_we),
        .ex_load  (ex_load),
        .id_src_a (id_src_a),
        .id_src_b (id_src_b),
        .stall    (stall)
    );

    always_comb begin
        ctl_d.stall = stall;
        ctl_d.flush = br_taken && !stall;
    end

    assign fwd_sel_a   = sel[0];
    assign fwd_sel_b   = sel[1];
    assign pc_hold     = ctl_d.stall;
    assign ifid_hold   = ctl_d.stall;
    assign idex_bubble = ctl_d.stall;
    assign ifid_flush  = ctl_d.flush;

    assert_lockstep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_hold == ifid_hold) && (ifid_hold == idex_bubble));

    assert_flush_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (br_taken && !idex_bubble) |-> ifid_flush);

    assert_flush_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ifid_flush |-> (br_taken && !pc_hold));
endmodule

// File: tb/hazard_unit_test.sv
module hazard_unit_test;
    logic clk = 0;
    logic rst_n = 0;
    always #5 clk = ~clk;

    logic [4:0] id_src_a, id_src_b, ex_src_a, ex_src_b, ex_dst, mem_dst, wb_dst;
    logic ex_we, ex_load, mem_we, wb_we, br_taken;
    logic [1:0] fwd_sel_a, fwd_sel_b;
    logic pc_hold, ifid_hold, idex_bubble, ifid_flush;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int bubbles;

    hazard_unit uut (.*);

    function automatic logic [1:0] exp_sel(input logic [4:0] s);
        if (s != 0 && mem_we && mem_dst == s) return 2'b10;
        if (s != 0 && wb_we && wb_dst == s) return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic exp_stall();
        return ex_load && ex_we && ex_dst != 0 && (ex_dst == id_src_a || ex_dst == id_src_b);
    endfunction

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        id_src_a = 0; id_src_b = 0; ex_src_a = 0; ex_src_b = 0; ex_dst = 0;
        mem_dst = 0; wb_dst = 0; ex_we = 0; ex_load = 0; mem_we = 0; wb_we = 0;
        br_taken = 0;
    endtask

    task automatic settle();
        #2;
    endtask

    task automatic check_all(input string tag);
        logic s;
        s = exp_stall();
        chk({tag, " R1/R2/R3/R9 sel_a"}, {2'b0, fwd_sel_a}, {2'b0, exp_sel(ex_src_a)});
        chk({tag, " R1/R2/R3/R9 sel_b"}, {2'b0, fwd_sel_b}, {2'b0, exp_sel(ex_src_b)});
        chk({tag, " R6/R7 stall"}, {1'b0, pc_hold, ifid_hold, idex_bubble}, {1'b0, s, s, s});
        chk({tag, " R8 flush"}, {3'b0, ifid_flush}, {3'b0, br_taken && !s});
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) cycles++;

    initial begin
        void'($urandom(32'd7351));
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        settle();
        chk("reset R4 sel_a", {2'b0, fwd_sel_a}, 4'd0);
        chk("reset R7 stall", {3'b0, pc_hold}, 4'd0);

        // add r1,r2,r3 ; sub r4,r1,r3 ; and r6,r1,r7 ; or r8,r1,r9
        @(negedge clk); idle();           // sub in EX, add in MEM
        ex_src_a = 1; ex_src_b = 3; ex_dst = 4; ex_we = 1;
        mem_dst = 1; mem_we = 1; settle();
        chk("chain R1 sub gets MEM", {2'b0, fwd_sel_a}, 4'h2);
        chk("chain R4 sub src_b", {2'b0, fwd_sel_b}, 4'h0);
        @(negedge clk); idle();           // and in EX, sub in MEM, add in WB
        ex_src_a = 1; ex_src_b = 7; ex_dst = 6; ex_we = 1;
        mem_dst = 4; mem_we = 1; wb_dst = 1; wb_we = 1; settle();
        chk("chain R2 and gets WB", {2'b0, fwd_sel_a}, 4'h1);
        @(negedge clk); idle();           // or in EX, add already written
        ex_src_a = 1; ex_src_b = 9; ex_dst = 8; ex_we = 1;
        mem_dst = 6; mem_we = 1; wb_dst = 4; wb_we = 1; settle();
        chk("chain R4 or reads regfile", {2'b0, fwd_sel_a}, 4'h0);

        // R3: both stages match
        @(negedge clk); idle();
        ex_src_a = 5; ex_src_b = 5; mem_dst = 5; mem_we = 1; wb_dst = 5; wb_we = 1; settle();
        chk("R3 MEM over WB", {2'b0, fwd_sel_a}, 4'h2);
        // R5: r0
        @(negedge clk); idle();
        ex_src_a = 0; mem_dst = 0; mem_we = 1; wb_dst = 0; wb_we = 1;
        ex_dst = 0; ex_we = 1; ex_load = 1; settle();
        chk("R5 r0 no bypass", {2'b0, fwd_sel_a}, 4'h0);
        chk("R5 r0 no stall", {3'b0, pc_hold}, 4'h0);

        // lw r1,0(r2) ; sub r4,r1,r3 : count bubbles
        bubbles = 0;
        @(negedge clk); idle();           // lw in EX, sub in ID
        ex_src_a = 2; ex_dst = 1; ex_we = 1; ex_load = 1;
        id_src_a = 1; id_src_b = 3; br_taken = 1; settle();
        bubbles += int'(idex_bubble);
        chk("R6 load-use stall", {1'b0, pc_hold, ifid_hold, idex_bubble}, 4'h7);
        chk("R8 no flush in stall", {3'b0, ifid_flush}, 4'h0);
        @(negedge clk); idle();           // bubble in EX, lw in MEM, sub held in ID
        id_src_a = 1; id_src_b = 3; mem_dst = 1; mem_we = 1; settle();
        bubbles += int'(idex_bubble);
        @(negedge clk); idle();           // sub in EX, bubble in MEM, lw in WB
        ex_src_a = 1; ex_src_b = 3; ex_dst = 4; ex_we = 1; wb_dst = 1; wb_we = 1; settle();
        bubbles += int'(idex_bubble);
        chk("R7 exactly one bubble", bubbles[3:0], 4'h1);
        chk("R2 sub gets load via WB", {2'b0, fwd_sel_a}, 4'h1);
        // R8 taken branch without stall
        @(negedge clk); idle(); br_taken = 1; settle();
        chk("R8 taken flush", {3'b0, ifid_flush}, 4'h1);

        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            id_src_a = 5'($urandom_range(0, 3)); id_src_b = 5'($urandom_range(0, 3));
            ex_src_a = 5'($urandom_range(0, 3)); ex_src_b = 5'($urandom_range(0, 3));
            ex_dst = 5'($urandom_range(0, 3)); mem_dst = 5'($urandom_range(0, 3));
            wb_dst = 5'($urandom_range(0, 3));
            ex_we = 1'($urandom); ex_load = 1'($urandom); mem_we = 1'($urandom);
            wb_we = 1'($urandom); br_taken = 1'($urandom);
            settle();
            check_all("rand");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule